// File: doc/BRIEF.md
# Debounced Two-Bank Cartridge Bank Switch

This block picks which half of an 8K cartridge ROM is visible to the host. The ROM is treated as two 4K banks. A single bank-select flop drives the ROM's top address line. The host processor's 13-bit address bus is asynchronous to the block and its bits settle at different moments, so a single look at the bus cannot be trusted. The block therefore runs from a free-running crystal oscillator of about 10 MHz. Every address bit passes through a two-flop synchronizer. A bank change is made only after the same hotspot address has been seen in several consecutive synchronized samples.

There are two hotspots, both inside the cartridge window, where address bit 12 is high. Offset 0xFF8 selects bank 0 and offset 0xFF9 selects bank 1. A run counter advances while the synchronized address keeps matching one hotspot. Any other sample restarts it, including the other hotspot. The counter saturates, so a hotspot that is held for a long time updates the bank only once. The ROM chip-enable and the lower twelve ROM address lines are wired straight from the bus with no added delay.

Top module: `cart_bank_qualifier`

## Requirements
- R1: While `rstN` is low, and after it is released, `bankSel` reads 1 (bank 1) until a qualified hotspot changes it.
- R2: `romCe` always equals `addrIn[12]`, combinationally.
- R3: `romAddr[11:0]` always equals `addrIn[11:0]`, combinationally, and `romAddr[12]` equals `bankSel`.
- R4: Address 0x1FF8 held for at least HOLD_CYCLES (default 3) consecutive synchronized samples sets `bankSel` to 0.
- R5: Address 0x1FF9 held for at least HOLD_CYCLES consecutive synchronized samples sets `bankSel` to 1.
- R6: A hotspot held for fewer than HOLD_CYCLES samples leaves `bankSel` unchanged.
- R7: Any sample that is not the same hotspot restarts the run. This covers a non-hotspot address and the other hotspot. Split runs whose pieces are each shorter than HOLD_CYCLES never switch, even when their sum is larger.
- R8: Hotspot offsets seen with `addrIn[12]` low (0x0FF8, 0x0FF9) have no effect on `bankSel`.
- R9: The run counter saturates at HOLD_CYCLES. A hotspot held indefinitely updates the bank once, and `bankSel` then stays put.
- R10: With the address driven just after a clock edge, `bankSel` takes its new value on the (SYNC_STAGES+HOLD_CYCLES)-th rising edge that follows. This is the 5th edge by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | 13 | Asynchronous cartridge address bus; bit 12 is the cartridge select |
| bankSel | output | 1 | Current bank; drives the ROM upper address line |
| romCe | output | 1 | ROM chip-enable, equal to `addrIn[12]` |
| romAddr | output | 13 | ROM address: `{bankSel, addrIn[11:0]}` |

## Verification
On every cycle, the assertions rebuild the run length from the synchronized address on their own. They check that the bank changes only on the sample that completes a run of exactly HOLD_CYCLES, and that it takes the hotspot's bank at that point. They also check that the internal counter never passes its limit and that a run held beyond the limit leaves the bank still. The effects seen at the ports can only be shown by the bench's scenarios. These are the exact edge on which the bank moves, split and crossed hotspot runs that must not switch, hotspots outside the cartridge window being ignored, the pass-through of the enable and low address lines, and the return to bank 1 on reset.

// File: rtl/cbq_pkg.sv
package cbq_pkg;

  // Hotspot decode result for one synchronized sample.
  typedef struct packed {
    logic hotValid;  // sample is one of the two hotspots
    logic hotBank;   // bank that hotspot selects
  } hotInfo_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadBank;  // write bank register this cycle
    logic nextBank;  // value to write
  } bankCtrl_t;

endpackage

// File: rtl/cbq_datapath.sv
module cbq_datapath
  import cbq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOT0_OFS    = 'hFF8,
  parameter int unsigned HOT1_OFS    = 'hFF9,
  parameter bit          RESET_BANK  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  bankCtrl_t         ctrl,
  output logic [ADDR_W-1:0] syncAddr,
  output hotInfo_t          hot,
  output logic              bankSel
);

  localparam int unsigned OFS_W   = ADDR_W - 1;
  localparam int unsigned SEL_BIT = ADDR_W - 1;
  localparam logic [OFS_W-1:0] HOT0 = OFS_W'(HOT0_OFS);
  localparam logic [OFS_W-1:0] HOT1 = OFS_W'(HOT1_OFS);

  // One synchronizer chain per address bit.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else if (SYNC_STAGES == 1) chain <= addrIn[b];
      else chain <= {chain[SYNC_STAGES-2:0], addrIn[b]};
    end
    assign syncAddr[b] = chain[SYNC_STAGES-1];
  end

  // Hotspot decode on the synchronized sample.
  logic [OFS_W-1:0] syncOfs;
  logic             syncSel;
  assign syncOfs = syncAddr[OFS_W-1:0];
  assign syncSel = syncAddr[SEL_BIT];

  always_comb begin
    hot.hotValid = 1'b0;
    hot.hotBank  = 1'b0;
    if (syncSel) begin
      if (syncOfs == HOT0) begin
        hot.hotValid = 1'b1;
        hot.hotBank  = 1'b0;
      end else if (syncOfs == HOT1) begin
        hot.hotValid = 1'b1;
        hot.hotBank  = 1'b1;
      end
    end
  end

  // Bank register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bankSel <= RESET_BANK;
    else if (ctrl.loadBank) bankSel <= ctrl.nextBank;
  end

endmodule

// File: rtl/cbq_control.sv
module cbq_control
  import cbq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 3,
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hotInfo_t         hot,
  output bankCtrl_t        ctrl,
  output logic [CNT_W-1:0] holdCnt
);

  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic             lastBank;
  logic             sameRun;
  logic [CNT_W-1:0] cntNext;

  // A sample continues the run only if it repeats the hotspot being counted.
  assign sameRun = hot.hotValid && (holdCnt != '0) && (hot.hotBank == lastBank);

  always_comb begin
    if (!hot.hotValid)        cntNext = '0;
    else if (!sameRun)        cntNext = CNT_W'(1);
    else if (holdCnt == CNT_MAX) cntNext = CNT_MAX;
    else                      cntNext = holdCnt + CNT_W'(1);
  end

  // Load fires only on the sample that completes the run.
  always_comb begin
    ctrl.nextBank = hot.hotBank;
    if (!hot.hotValid)  ctrl.loadBank = 1'b0;
    else if (sameRun)   ctrl.loadBank = (holdCnt == CNT_LAST);
    else                ctrl.loadBank = (HOLD_CYCLES == 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      lastBank <= 1'b0;
    end else begin
      holdCnt <= cntNext;
      if (hot.hotValid) lastBank <= hot.hotBank;
    end
  end

endmodule

// File: rtl/cart_bank_qualifier.sv
module cart_bank_qualifier
  import cbq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYCLES = 3,
  parameter int unsigned HOT0_OFS    = 'hFF8,
  parameter int unsigned HOT1_OFS    = 'hFF9,
  parameter bit          RESET_BANK  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              bankSel,
  output logic              romCe,
  output logic [ADDR_W-1:0] romAddr
);

  localparam int unsigned OFS_W = ADDR_W - 1;
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [ADDR_W-1:0] syncAddr;
  hotInfo_t          hot;
  bankCtrl_t         ctrl;
  logic [CNT_W-1:0]  holdCnt;

  cbq_datapath #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .HOT0_OFS(HOT0_OFS), .HOT1_OFS(HOT1_OFS), .RESET_BANK(RESET_BANK)
  ) dp_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ctrl(ctrl),
    .syncAddr(syncAddr), .hot(hot), .bankSel(bankSel)
  );

  cbq_control #(.HOLD_CYCLES(HOLD_CYCLES)) ctl_i (
    .clk(clk), .rstN(rstN), .hot(hot), .ctrl(ctrl), .holdCnt(holdCnt)
  );

  assign romCe   = addrIn[ADDR_W-1];
  assign romAddr = {bankSel, addrIn[OFS_W-1:0]};

endmodule

// File: rtl/cbq_checker.sv
module cbq_checker #(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned HOLD_CYCLES = 3,
  parameter int unsigned HOT0_OFS    = 'hFF8,
  parameter int unsigned HOT1_OFS    = 'hFF9,
  parameter bit          RESET_BANK  = 1'b1,
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] syncAddr,
  input logic              bankSel,
  input logic [CNT_W-1:0]  holdCnt
);

  localparam int unsigned OFS_W = ADDR_W - 1;

  // Independent run-length model of the synchronized address.
  logic [ADDR_W-1:0] prevAddr;
  logic [15:0]       runCnt;
  logic              runBank;
  logic              isHot;

  assign isHot = syncAddr[ADDR_W-1] &&
                 ((syncAddr[OFS_W-1:0] == OFS_W'(HOT0_OFS)) ||
                  (syncAddr[OFS_W-1:0] == OFS_W'(HOT1_OFS)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAddr <= '0;
      runCnt   <= '0;
      runBank  <= 1'b0;
    end else begin
      prevAddr <= syncAddr;
      runBank  <= (syncAddr[OFS_W-1:0] == OFS_W'(HOT1_OFS));
      if (!isHot)                                  runCnt <= '0;
      else if (runCnt != '0 && syncAddr == prevAddr)
        runCnt <= (runCnt > 16'(HOLD_CYCLES)) ? runCnt : runCnt + 16'd1;
      else                                         runCnt <= 16'd1;
    end
  end

  // R1: reset forces the bank register to its reset bank
  a_r1_reset_bank: assert property (@(posedge clk)
    !rstN |=> bankSel == RESET_BANK);

  // R6 / R7: the bank only moves on the sample completing a full run
  a_r6_change_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (bankSel != $past(bankSel)) |-> runCnt == 16'(HOLD_CYCLES));

  // R4 / R5: a completed run selects that hotspot's bank
  a_r5_bank_follows_hotspot: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == 16'(HOLD_CYCLES) && $past(runCnt) == 16'(HOLD_CYCLES - 1))
      |-> bankSel == runBank);

  // R9: counter bounded
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_W'(HOLD_CYCLES));

  // R9: a run held past the limit causes no further update
  a_r9_held_stable: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt > 16'(HOLD_CYCLES)) |-> $stable(bankSel));

endmodule

bind cart_bank_qualifier cbq_checker #(
  .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES),
  .HOT0_OFS(HOT0_OFS), .HOT1_OFS(HOT1_OFS), .RESET_BANK(RESET_BANK)
) chk_i (
  .clk(clk), .rstN(rstN), .syncAddr(syncAddr), .bankSel(bankSel), .holdCnt(holdCnt)
);

// File: tb/cart_bank_qualifier_tb_top.sv
module cart_bank_qualifier_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] addrIn = '0;
  logic        bankSel;
  logic        romCe;
  logic [12:0] romAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cart_bank_qualifier dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .bankSel(bankSel), .romCe(romCe), .romAddr(romAddr)
  );

  // Vector table: address, edges held, expected bank afterwards.
  localparam int NVEC = 8;
  localparam logic [12:0] VEC_ADDR [NVEC] =
    '{13'h1FF8, 13'h1FF9, 13'h1FF9, 13'h0FF8, 13'h1FF8, 13'h0FF9, 13'h1FF7, 13'h1FF9};
  localparam int VEC_HOLD [NVEC] = '{3, 2, 3, 8, 20, 8, 5, 5};
  localparam bit VEC_BANK [NVEC] = '{0, 0, 1, 1, 0, 0, 0, 1};
  localparam string VEC_REQ [NVEC] =
    '{"R4", "R6", "R5", "R8", "R9", "R8", "R7", "R5"};

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive addr just after a falling edge; hold it for n rising edges.
  task automatic present(input logic [12:0] a, input int n);
    @(negedge clk);
    addrIn = a;
    repeat (n) @(posedge clk);
  endtask

  task automatic settle();
    present(13'h0000, 6);
    @(negedge clk);
  endtask

  initial begin
    // Reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R1 reset", bankSel, 1);
    checkVal("R2 reset ce", romCe, 0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkVal("R1 after release", bankSel, 1);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      present(VEC_ADDR[i], VEC_HOLD[i]);
      settle();
      checkVal(VEC_REQ[i], bankSel, VEC_BANK[i]);
    end

    // R10: switch lands on the 5th edge after the drive
    @(negedge clk);
    addrIn = 13'h1FF8;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checkVal("R10 before", bankSel, 1);
    @(posedge clk);
    @(negedge clk);
    checkVal("R10 on edge", bankSel, 0);
    settle();

    // R7: split run of the same hotspot
    present(13'h1FF9, 2);
    present(13'h1000, 1);
    present(13'h1FF9, 2);
    settle();
    checkVal("R7 split run", bankSel, 0);

    // R7: crossing hotspots restarts the count
    present(13'h1FF8, 2);
    present(13'h1FF9, 2);
    settle();
    checkVal("R7 crossed hotspots", bankSel, 0);

    // R2 / R3: pass-through of enable and low lines
    @(negedge clk);
    addrIn = 13'h0123;
    #1;
    checkVal("R2 ce low", romCe, 0);
    checkVal("R3 addr", romAddr, 13'h0123);
    addrIn = 13'h1ABC;
    #1;
    checkVal("R2 ce high", romCe, 1);
    checkVal("R3 addr", romAddr, 13'h0ABC);
    present(13'h1FF9, 3);
    settle();
    addrIn = 13'h1FFF;
    #1;
    checkVal("R3 upper line", romAddr, 13'h1FFF);
    addrIn = 13'h0000;

    // R1: reset mid-run returns to bank 1
    present(13'h1FF8, 3);
    settle();
    checkVal("R4 before reset", bankSel, 0);
    rstN = 1'b0;
    #1;
    checkVal("R1 async reset", bankSel, 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checkVal("R1 after re-release", bankSel, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule